// File: doc/BRIEF.md
# Almost-Flag Offset Register Loader

This block sets up the four offset registers that a pair of FIFOs uses to place their almost-full and almost-empty flags. There are two methods, and the three mode-select pins choose between them when the synchronous reset is released. In preset mode, all four offsets come from a small table indexed by the pins. The loader is ready on the first cycle after reset.

In parallel mode, the first four writes on port A are taken as configuration and are not stored as FIFO data. They fill the registers in a fixed order: full offset of FIFO A, empty offset of FIFO A, full offset of FIFO B, empty offset of FIFO B. The offset is taken from each 36-bit word in one of two bit layouts. The layout is also chosen at reset release: a flat layout, or a layout that skips the parity position at bit 8.

Once all four offsets are valid, the loader raises its done flag. From then on it passes port A writes through to the FIFO storage.

Top module: `ofs_cfg_loader`

## Requirements
- R1: With `mode_sel` = 3'b111 at reset release, all four offsets read 64 and `cfg_done` is high on the first cycle after reset.
- R2: In preset mode, the codes map to these values: 3'b001 gives 8, 3'b010 gives 16, 3'b011 gives 256 and 3'b101 gives 1024. The same value goes to all four offsets, and `cfg_done` is high right after reset.
- R3: Code 3'b110 has no table entry. It loads 64 into all four offsets and behaves as preset mode.
- R4: Codes with `mode_sel[1:0]` = 2'b00 select parallel mode, and `cfg_done` stays low through the first three accepted writes. It goes high in the cycle after the fourth accepted write, and idle cycles between writes do not advance the count.
- R5: The parallel writes load, in order: `full_ofs_a`, `empty_ofs_a`, `full_ofs_b`, `empty_ofs_b`. Until its slot is written, each register holds 64.
- R6: With code 3'b000 (flat layout), the offset is `a_wr_data[12:0]` and all other data bits are ignored.
- R7: With code 3'b100 (parity-skip layout), the offset is {`a_wr_data[13:9]`, `a_wr_data[7:0]`} with bit 13 as the MSB. Bit 8 and bits 35:14 are ignored.
- R8: A configuration offset of 0 is stored as 1, and one above 8188 is stored as 8188. Either case sets `cfg_err`, which stays high until the next reset and is low after reset. Every offset stays in the range 1 to 8188.
- R9: `fifo_wr_en` follows `a_wr_en` only while `cfg_done` is high, so none of the four configuration writes reaches the FIFO.
- R10: After `cfg_done` rises, it stays high until reset. The offsets no longer change, whatever happens on `a_wr_en`, `a_wr_data` or `mode_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; `mode_sel` is captured while it is high |
| mode_sel | input | 3 | Loading method, layout and preset code |
| a_wr_en | input | 1 | Port A write strobe |
| a_wr_data | input | 36 | Port A write data |
| full_ofs_a | output | 13 | Almost-full offset, FIFO A |
| empty_ofs_a | output | 13 | Almost-empty offset, FIFO A |
| full_ofs_b | output | 13 | Almost-full offset, FIFO B |
| empty_ofs_b | output | 13 | Almost-empty offset, FIFO B |
| cfg_done | output | 1 | All offsets valid |
| cfg_err | output | 1 | A configuration offset was clamped |
| fifo_wr_en | output | 1 | Port A write forwarded to the FIFO |

## Verification
The hardest case to reach is a parallel load in which writes are spread over idle cycles. In that case, an out-of-range value, or stray bits in the unused positions of the word, land in one particular slot. The bench goes through a new reset for every trial and draws the select code at random, so both layouts and every preset code come up. Each field value is placed into random noise according to the layout, and the values are biased toward 0, 8188, 8189 and the all-ones field. Directed cases pin the ignored parity bit and the undefined preset code. After loading, the bench toggles `mode_sel` and keeps writing, to show that the offsets are frozen.

// File: rtl/ofs_cfg_pkg.sv
package ofs_cfg_pkg;

    typedef enum logic [1:0] {
        LOAD_PRESET   = 2'd0,
        LOAD_PAR_FLAT = 2'd1,
        LOAD_PAR_IP   = 2'd2
    } load_mode_e;

    localparam int NUM_OFS         = 4;
    localparam int FALLBACK_PRESET = 64;

    // Method chosen by the select pins: low two bits zero means port A loading.
    function automatic load_mode_e decode_mode(input logic [2:0] sel);
        if (sel[1:0] == 2'b00)
            return sel[2] ? LOAD_PAR_IP : LOAD_PAR_FLAT;
        return LOAD_PRESET;
    endfunction

    // Preset lookup; parallel codes and undefined codes give the fallback.
    function automatic int unsigned preset_value(input logic [2:0] sel);
        case (sel)
            3'b001:  return 8;
            3'b010:  return 16;
            3'b011:  return 256;
            3'b101:  return 1024;
            default: return FALLBACK_PRESET;
        endcase
    endfunction

endpackage

// File: rtl/cfg_mode_latch.sv
module cfg_mode_latch
    import ofs_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_sel,
    output logic       interspersed
);
    load_mode_e mode_q;

    // Mode is sampled only while reset is held; later pin activity is ignored.
    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= decode_mode(mode_sel);
    end

    assign interspersed = (mode_q == LOAD_PAR_IP);
endmodule

// File: rtl/cfg_word_extract.sv
module cfg_word_extract #(
    parameter int DATA_W  = 36,
    parameter int OFS_W   = 13,
    parameter int MAX_OFS = 8188
) (
    input  logic [DATA_W-1:0] data,
    input  logic              interspersed,
    output logic [OFS_W-1:0]  value,
    output logic              clamped
);
    localparam logic [OFS_W-1:0] MAX_V = OFS_W'(MAX_OFS);

    logic [OFS_W-1:0] raw;
    logic             unused_hi_bits;

    assign unused_hi_bits = ^data[DATA_W-1:OFS_W+1];

    // The parity-skip layout drops bit 8 and shifts the upper part down by one.
    always_comb begin
        if (interspersed)
            raw = {data[OFS_W:9], data[7:0]};
        else
            raw = data[OFS_W-1:0];
    end

    always_comb begin
        clamped = 1'b0;
        value   = raw;
        if (raw == '0) begin
            value   = OFS_W'(1);
            clamped = 1'b1;
        end else if (raw > MAX_V) begin
            value   = MAX_V;
            clamped = 1'b1;
        end
    end
endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
    import ofs_cfg_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_sel,
    input  logic              wr_en,
    output logic              take,
    output logic [SLOT_W-1:0] slot,
    output logic              done
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    assign take = wr_en & ~done;

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= (decode_mode(mode_sel) == LOAD_PRESET);
            slot <= '0;
        end else if (take) begin
            slot <= slot + SLOT_W'(1);
            if (slot == LAST)
                done <= 1'b1;
        end
    end
endmodule

// File: rtl/cfg_ofs_bank.sv
module cfg_ofs_bank #(
    parameter int OFS_W  = 13,
    parameter int SLOTS  = 4,
    parameter int SLOT_W = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [OFS_W-1:0]            preset,
    input  logic                        take,
    input  logic [SLOT_W-1:0]           slot,
    input  logic [OFS_W-1:0]            wr_value,
    output logic [SLOTS-1:0][OFS_W-1:0] ofs
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                ofs[i] <= preset;
            else if (take && slot == SLOT_W'(i))
                ofs[i] <= wr_value;
        end
    end
endmodule

// File: rtl/ofs_cfg_loader.sv
module ofs_cfg_loader
    import ofs_cfg_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int DEPTH  = 8192
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [2:0]                mode_sel,
    input  logic                      a_wr_en,
    input  logic [DATA_W-1:0]         a_wr_data,
    output logic [$clog2(DEPTH)-1:0]  full_ofs_a,
    output logic [$clog2(DEPTH)-1:0]  empty_ofs_a,
    output logic [$clog2(DEPTH)-1:0]  full_ofs_b,
    output logic [$clog2(DEPTH)-1:0]  empty_ofs_b,
    output logic                      cfg_done,
    output logic                      cfg_err,
    output logic                      fifo_wr_en
);
    localparam int OFS_W   = $clog2(DEPTH);
    localparam int MAX_OFS = DEPTH - 4;
    localparam int SLOT_W  = $clog2(NUM_OFS);

    logic                          interspersed;
    logic                          take;
    logic [SLOT_W-1:0]             slot;
    logic [OFS_W-1:0]              wr_value;
    logic                          clamped;
    logic [NUM_OFS-1:0][OFS_W-1:0] ofs;
    logic [OFS_W-1:0]              preset;

    assign preset = OFS_W'(preset_value(mode_sel));

    cfg_mode_latch u_mode (
        .clk          (clk),
        .rst          (rst),
        .mode_sel     (mode_sel),
        .interspersed (interspersed)
    );

    cfg_load_seq #(.SLOTS(NUM_OFS), .SLOT_W(SLOT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .wr_en    (a_wr_en),
        .take     (take),
        .slot     (slot),
        .done     (cfg_done)
    );

    cfg_word_extract #(.DATA_W(DATA_W), .OFS_W(OFS_W), .MAX_OFS(MAX_OFS)) u_ext (
        .data         (a_wr_data),
        .interspersed (interspersed),
        .value        (wr_value),
        .clamped      (clamped)
    );

    cfg_ofs_bank #(.OFS_W(OFS_W), .SLOTS(NUM_OFS), .SLOT_W(SLOT_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .preset   (preset),
        .take     (take),
        .slot     (slot),
        .wr_value (wr_value),
        .ofs      (ofs)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cfg_err <= 1'b0;
        else if (take && clamped)
            cfg_err <= 1'b1;
    end

    // Slot order: full A, empty A, full B, empty B.
    assign full_ofs_a  = ofs[0];
    assign empty_ofs_a = ofs[1];
    assign full_ofs_b  = ofs[2];
    assign empty_ofs_b = ofs[3];
    assign fifo_wr_en  = a_wr_en & cfg_done;
endmodule

// File: rtl/ofs_cfg_loader_chk.sv
module ofs_cfg_loader_chk #(
    parameter int OFS_W   = 13,
    parameter int MAX_OFS = 8188
) (
    input logic             clk,
    input logic             rst,
    input logic             a_wr_en,
    input logic             cfg_done,
    input logic             cfg_err,
    input logic [OFS_W-1:0] full_ofs_a,
    input logic [OFS_W-1:0] empty_ofs_a,
    input logic [OFS_W-1:0] full_ofs_b,
    input logic [OFS_W-1:0] empty_ofs_b
);
    localparam logic [OFS_W-1:0] MAX_V = OFS_W'(MAX_OFS);

    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> cfg_done);

    // R10
    ofs_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> ($stable(full_ofs_a) && $stable(empty_ofs_a)
                      && $stable(full_ofs_b) && $stable(empty_ofs_b)));

    // R8
    ofs_range_chk: assert property (@(posedge clk) disable iff (rst)
        (full_ofs_a != '0 && full_ofs_a <= MAX_V && empty_ofs_a != '0 && empty_ofs_a <= MAX_V
         && full_ofs_b != '0 && full_ofs_b <= MAX_V && empty_ofs_b != '0 && empty_ofs_b <= MAX_V));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_err) |-> ($past(a_wr_en) && !$past(cfg_done)));

    // R4
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(cfg_done) && !$past(rst)) |-> $past(a_wr_en));
endmodule

bind ofs_cfg_loader ofs_cfg_loader_chk #(.OFS_W(OFS_W), .MAX_OFS(MAX_OFS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .a_wr_en     (a_wr_en),
    .cfg_done    (cfg_done),
    .cfg_err     (cfg_err),
    .full_ofs_a  (full_ofs_a),
    .empty_ofs_a (empty_ofs_a),
    .full_ofs_b  (full_ofs_b),
    .empty_ofs_b (empty_ofs_b)
);

// File: tb/ofs_cfg_loader_bench.sv
module ofs_cfg_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXV = 8188;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_sel = 3'b111;
    logic        a_wr_en = 1'b0;
    logic [35:0] a_wr_data = '0;
    logic [12:0] full_ofs_a, empty_ofs_a, full_ofs_b, empty_ofs_b;
    logic        cfg_done, cfg_err, fifo_wr_en;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int exp_ofs [4];
    bit exp_done, exp_err, exp_ip;
    int exp_slot;

    always #(CLK_PERIOD/2) clk = ~clk;

    ofs_cfg_loader u_ofs_cfg_loader (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .a_wr_en(a_wr_en), .a_wr_data(a_wr_data),
        .full_ofs_a(full_ofs_a), .empty_ofs_a(empty_ofs_a),
        .full_ofs_b(full_ofs_b), .empty_ofs_b(empty_ofs_b),
        .cfg_done(cfg_done), .cfg_err(cfg_err), .fifo_wr_en(fifo_wr_en)
    );

    function automatic int exp_preset(input logic [2:0] s);
        case (s)
            3'b001:  return 8;
            3'b010:  return 16;
            3'b011:  return 256;
            3'b101:  return 1024;
            default: return 64;
        endcase
    endfunction

    function automatic int raw_field(input logic [35:0] d, input bit ip);
        if (ip) return int'({d[13:9], d[7:0]});
        return int'(d[12:0]);
    endfunction

    function automatic logic [35:0] place(input int v, input bit ip, input logic [35:0] noise);
        logic [35:0] d = noise;
        logic [12:0] f = 13'(v);
        if (ip) begin
            d[13:9] = f[12:8];
            d[7:0]  = f[7:0];
        end else begin
            d[12:0] = f;
        end
        return d;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " full_a"},  int'(full_ofs_a),  exp_ofs[0]);
        check({tag, " empty_a"}, int'(empty_ofs_a), exp_ofs[1]);
        check({tag, " full_b"},  int'(full_ofs_b),  exp_ofs[2]);
        check({tag, " empty_b"}, int'(empty_ofs_b), exp_ofs[3]);
        check({tag, " done"},    int'(cfg_done),    int'(exp_done));
        check({tag, " err"},     int'(cfg_err),     int'(exp_err));
    endtask

    task automatic do_reset(input logic [2:0] s);
        @(negedge clk);
        rst = 1'b1; mode_sel = s; a_wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) exp_ofs[i] = exp_preset(s);
        exp_done = (s[1:0] != 2'b00);
        exp_err  = 1'b0;
        exp_ip   = s[2];
        exp_slot = 0;
    endtask

    // Called at a negedge; returns at the next negedge with outputs updated.
    task automatic wr(input logic [35:0] d, input string tag);
        int raw;
        int v;
        a_wr_en = 1'b1; a_wr_data = d;
        #1;
        check({tag, " R9 pass"}, int'(fifo_wr_en), int'(exp_done));
        if (!exp_done) begin
            raw = raw_field(d, exp_ip);
            v = (raw == 0) ? 1 : (raw > MAXV ? MAXV : raw);
            if (raw == 0 || raw > MAXV) exp_err = 1'b1;
            exp_ofs[exp_slot] = v;
            exp_slot++;
            if (exp_slot == 4) exp_done = 1'b1;
        end
        @(negedge clk);
        a_wr_en = 1'b0;
    endtask

    function automatic int pick_val();
        case ($urandom % 6)
            0: return 0;
            1: return MAXV;
            2: return MAXV + 1;
            3: return 8191;
            default: return 1 + ($urandom % MAXV);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));

        // R1: all-high preset
        do_reset(3'b111);
        check_all("R1 preset64");
        wr(36'h0_0000_0005, "R10 post");
        check_all("R10 preset frozen");

        // R2, R3: preset table
        do_reset(3'b001); check_all("R2 code001");
        do_reset(3'b010); check_all("R2 code010");
        do_reset(3'b011); check_all("R2 code011");
        do_reset(3'b101); check_all("R2 code101");
        do_reset(3'b110); check_all("R3 code110");

        // R4, R5, R6: flat layout with idle gaps and noise above bit 12
        do_reset(3'b000);
        check_all("R4 par start");
        wr(place(100, 0, 36'hF_FFFF_E000), "R6 w0");
        check_all("R5 slot0");
        @(negedge clk);
        wr(place(200, 0, 36'hA_5A5A_0000), "R6 w1");
        check_all("R5 slot1");
        wr(place(300, 0, '0), "R6 w2");
        repeat (3) @(negedge clk);
        check_all("R4 idle three");
        wr(place(400, 0, '0), "R6 w3");
        check_all("R4 done after four");
        mode_sel = 3'b111;
        wr(place(7, 0, '0), "R10 after");
        check_all("R10 frozen");

        // R7: parity-skip layout, bit 8 set must be ignored
        do_reset(3'b100);
        wr(36'h0_0000_0105, "R7 w0");
        check_all("R7 bit8 ignored");
        wr(place(8000, 1, 36'hF_FFFF_C100), "R7 w1");
        wr(place(0, 1, '0), "R8 zero");
        wr(place(8191, 1, '0), "R8 top");
        check_all("R8 clamp ip");

        // R8: flat clamps and reset clearing the error
        do_reset(3'b000);
        wr(place(MAXV + 1, 0, '0), "R8 w0");
        wr(place(MAXV, 0, '0), "R8 w1");
        wr(place(1, 0, '0), "R8 w2");
        wr(place(0, 0, '0), "R8 w3");
        check_all("R8 clamp flat");
        do_reset(3'b000);
        check_all("R8 err cleared");

        // Random trials
        for (int t = 0; t < 60; t++) begin
            logic [2:0] s;
            s = 3'($urandom % 8);
            do_reset(s);
            check_all("R2 rand reset");
            for (int k = 0; k < 6; k++) begin
                logic [35:0] noise;
                noise = {4'($urandom), 32'($urandom)};
                if ($urandom % 3 == 0) @(negedge clk);
                wr(place(pick_val(), exp_ip, noise), "R9 rand");
                check_all("R5 rand load");
            end
            mode_sel = 3'($urandom % 8);
            @(negedge clk);
            check_all("R10 rand sel change");
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule